// File: doc/BRIEF.md
# Staggered Output Sequencer

This block sits between a latched target vector and a row of physical channel drives. When a start event is seen, it does not switch all channels at once. It takes a snapshot of the target vector and then updates one channel at a time. Channel 0 moves first, after a fixed base latency. Each later channel follows its lower neighbour by a fixed step. Spreading the switching this way limits the current surge on the supply rails. The block runs on a fast tick clock. The slower serial clock, the latch strobe and the active-low enable arrive as plain levels, and edges on them are detected in the tick domain.

Three events start or restart the cascade:
- the enable falls;
- the latch strobe rises while the enable is low;
- the serial clock rises while the enable is low and the latch strobe is high.

A start event that arrives mid-cascade begins again from channel 0 with the newest target. Driving the enable high blanks every channel and drops the cascade. A busy flag shows when a cascade is in progress.

All pins are plain control and status levels. The target vector is a level, not a stream: there is no valid/ready handshake and no back-pressure. The vector is sampled only on the tick edge that accepts a start event. It is ignored at every other time.

Top module: `stagger_drive_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, every drive bit is 0 and the busy flag is 0.
- R2: A tick edge that samples `oe_n_i` low, where the previous sample was high, is a start event. It captures `tgt_i` as the new snapshot.
- R3: A tick edge that samples `le_i` high, where the previous sample was low, while `oe_n_i` is low, is a start event.
- R4: A tick edge that samples `sck_i` high, where the previous sample was low, while `oe_n_i` is low and `le_i` is high, is a start event.
- R5: Take the start edge as edge 0. Drive bit k takes its snapshot value on edge LAT + k*STEP, where LAT defaults to 2 and STEP defaults to 1. Until that edge, bit k keeps its previous value.
- R6: The busy flag is 1 after the start edge. It returns to 0 on the same edge on which the last channel (bit N-1) is updated.
- R7: Any edge that samples `oe_n_i` high clears all drive bits to 0 and clears busy, abandoning any cascade.
- R8: A start event during a cascade restarts the cascade from channel 0 with the target present at that edge. The restarting edge itself changes no drive bit.
- R9: With no start event, the drive bits do not change. This covers a target change while idle, a latch-strobe rise while `oe_n_i` is high, and a serial-clock rise while `le_i` is low.
- R10: A change of `tgt_i` after the start edge has no effect on the running cascade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_i | input | N | Target state for each channel, from the latch stage |
| oe_n_i | input | 1 | Active-low enable; high blanks all channels |
| le_i | input | 1 | Latch strobe level |
| sck_i | input | 1 | Serial clock level |
| drv_o | output | N | Staggered channel drives |
| busy_o | output | 1 | A cascade is in progress |

## Verification
A wrong cycle counter, or a wrong per-channel fire time, shows up as one drive bit switching an edge early or late. The drive bits are compared on every tick between the start edge and the end of the cascade, so an off-by-one error is caught within LAT + (N-1)*STEP ticks. A stale or missed snapshot shows as wrong bit values as soon as channel 0 updates, two ticks after the start edge. A busy flag that does not return to 0 is seen on the tick after the last channel update. A missing restart shows on the tick after the restarting edge, where some bit keeps moving on the old schedule. A wrong edge detector shows within one tick: busy either rises without a valid start event or fails to rise after one.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Tick edge, counted from the start edge, on which channel k is updated.
  function automatic int fire_edge(input int k, input int lat, input int step);
    return lat + k * step;
  endfunction

  // Tick edge on which the last of n channels is updated.
  function automatic int last_edge(input int n, input int lat, input int step);
    return lat + (n - 1) * step;
  endfunction

endpackage

// File: rtl/stg_trigger_detect.sv
module stg_trigger_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  input  logic le_i,
  input  logic sck_i,
  output logic trig_o
);
  logic prev_oe_n_q, prev_le_q, prev_sck_q;
  logic oe_fall, le_rise, sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_oe_n_q <= 1'b1;
      prev_le_q   <= 1'b0;
      prev_sck_q  <= 1'b0;
    end else begin
      prev_oe_n_q <= oe_n_i;
      prev_le_q   <= le_i;
      prev_sck_q  <= sck_i;
    end
  end

  always_comb begin
    oe_fall  = prev_oe_n_q & ~oe_n_i;
    le_rise  = ~prev_le_q & le_i & ~oe_n_i;
    sck_rise = ~prev_sck_q & sck_i & ~oe_n_i & le_i;
    trig_o   = oe_fall | le_rise | sck_rise;
  end

  // R3: a start event is never raised while the enable is high
  a_r3_no_trig_when_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !trig_o);

endmodule

// File: rtl/stg_seq_timer.sv
module stg_seq_timer #(
  parameter int N    = 16,
  parameter int LAT  = 2,
  parameter int STEP = 1,
  parameter int TW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          clr_i,
  output logic          busy_o,
  output logic [TW-1:0] tcnt_o
);
  import stagger_pkg::*;
  localparam int LAST = last_edge(N, LAT, STEP);

  logic          busy_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      tcnt_q <= TW'(1);
    end else if (busy_q) begin
      if (tcnt_q == TW'(LAST)) begin
        busy_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + TW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign tcnt_o = tcnt_q;

  // R8: every start event restarts the count at one
  a_r8_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !clr_i) |=> (busy_q && tcnt_q == TW'(1)));

  // R6: the counter never runs past the last channel's edge
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tcnt_q != '0 && tcnt_q <= TW'(LAST)));

endmodule

// File: rtl/stg_chan_bank.sv
module stg_chan_bank #(
  parameter int N    = 16,
  parameter int LAT  = 2,
  parameter int STEP = 1,
  parameter int TW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  tgt_i,
  input  logic          trig_i,
  input  logic          clr_i,
  input  logic          busy_i,
  input  logic [TW-1:0] tcnt_i,
  output logic [N-1:0]  fire_o,
  output logic [N-1:0]  drv_o
);
  import stagger_pkg::*;

  logic [N-1:0] snap_q;
  logic [N-1:0] drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (trig_i) snap_q <= tgt_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_chan
    localparam int FT = fire_edge(k, LAT, STEP);
    assign fire_o[k] = busy_i && !trig_i && (tcnt_i == TW'(FT));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         drv_q[k] <= 1'b0;
      else if (clr_i)     drv_q[k] <= 1'b0;
      else if (fire_o[k]) drv_q[k] <= snap_q[k];
    end
  end

  assign drv_o = drv_q;

  // R5: at most one channel is updated per tick
  a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_o));

  // R7: blanking leaves every drive off
  a_r7_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (drv_q == '0));

  // R9: with no update and no blanking, the drives hold
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && fire_o == '0) |=> $stable(drv_q));

endmodule

// File: rtl/stagger_drive_seq.sv
module stagger_drive_seq #(
  parameter int N    = 16,
  parameter int LAT  = 2,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tgt_i,
  input  logic         oe_n_i,
  input  logic         le_i,
  input  logic         sck_i,
  output logic [N-1:0] drv_o,
  output logic         busy_o
);
  import stagger_pkg::*;
  localparam int LAST = last_edge(N, LAT, STEP);
  localparam int TW   = $clog2(LAST + 2);

  logic          trig_w;
  logic          busy_w;
  logic [TW-1:0] tcnt_w;
  logic [N-1:0]  fire_w;

  stg_trigger_detect u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_n_i (oe_n_i),
    .le_i   (le_i),
    .sck_i  (sck_i),
    .trig_o (trig_w)
  );

  stg_seq_timer #(.N(N), .LAT(LAT), .STEP(STEP), .TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_w),
    .clr_i  (oe_n_i),
    .busy_o (busy_w),
    .tcnt_o (tcnt_w)
  );

  stg_chan_bank #(.N(N), .LAT(LAT), .STEP(STEP), .TW(TW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_i  (tgt_i),
    .trig_i (trig_w),
    .clr_i  (oe_n_i),
    .busy_i (busy_w),
    .tcnt_i (tcnt_w),
    .fire_o (fire_w),
    .drv_o  (drv_o)
  );

  assign busy_o = busy_w;

  // R2: a sampled enable fall starts a cascade
  a_r2_oe_fall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_i && $past(oe_n_i)) |=> busy_o);

  // R6: busy ends without blanking only after the last channel fired
  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(oe_n_i)) |-> $past(fire_w[N-1]));

endmodule

// File: tb/stagger_drive_seq_bench.sv
module stagger_drive_seq_bench;
  localparam int N    = 16;
  localparam int LAT  = 2;
  localparam int STEP = 1;
  localparam int LAST = LAT + (N - 1) * STEP;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] tgt = '0;
  logic         oe_n = 1'b1, le = 1'b0, sck = 1'b0;
  logic [N-1:0] drv;
  logic         busy;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stagger_drive_seq #(.N(N), .LAT(LAT), .STEP(STEP)) u_stagger_drive_seq (
    .clk(clk), .rst_n(rst_n), .tgt_i(tgt), .oe_n_i(oe_n), .le_i(le),
    .sck_i(sck), .drv_o(drv), .busy_o(busy)
  );

  // kind[17:16]: 0 enable fall, 1 strobe rise, 2 serial clock rise; pattern[15:0]
  localparam logic [17:0] VEC [0:5] = '{
    18'h0FFFF, 18'h08001, 18'h15A3C, 18'h10000, 18'h2F00F, 18'h21234
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] exp_at(input logic [N-1:0] old, input logic [N-1:0] nw, input int j);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = (j >= LAT + k * STEP) ? nw[k] : old[k];
    return r;
  endfunction

  // Trigger inputs already driven; check from the start edge (j=0) to lastj.
  task automatic run_seq(input string req, input logic [N-1:0] old, input logic [N-1:0] nw, input int lastj);
    for (int j = 0; j <= lastj; j++) begin
      tick();
      chk({req, "/R5 drive"}, 32'(drv), 32'(exp_at(old, nw, j)));
      chk("R6 busy", 32'(busy), 32'(j < LAST));
      if (j == 0) tgt = ~nw;  // R10: later target change must be ignored
    end
  endtask

  task automatic blank_prep();
    oe_n = 1'b1; le = 1'b0; sck = 1'b0; tgt = '0;
    tick(); tick();
    chk("R7 blank", 32'({busy, drv}), 32'(0));
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pre, pre2, base;
    repeat (3) @(negedge clk);
    chk("R1 reset", 32'({busy, drv}), 32'(0));
    rst_n = 1'b1;
    tick();
    chk("R1 after release", 32'({busy, drv}), 32'(0));

    for (int v = 0; v < 6; v++) begin
      logic [1:0]   kind;
      logic [N-1:0] pat;
      kind = VEC[v][17:16];
      pat  = VEC[v][15:0];
      blank_prep();
      pre  = 16'hA5A5;
      pre2 = 16'h0FF0;
      if (kind == 2'd0) begin
        tgt = pat; oe_n = 1'b0;
        run_seq("R2", '0, pat, LAST + 1);
      end else if (kind == 2'd1) begin
        tgt = pre; oe_n = 1'b0;
        run_seq("R2", '0, pre, LAST + 1);
        tgt = pat; le = 1'b1;
        run_seq("R3", pre, pat, LAST + 1);
      end else begin
        tgt = pre; oe_n = 1'b0;
        run_seq("R2", '0, pre, LAST + 1);
        tgt = pre2; le = 1'b1;
        run_seq("R3", pre, pre2, LAST + 1);
        tgt = pat; sck = 1'b1;
        run_seq("R4", pre2, pat, LAST + 1);
        sck = 1'b0;
      end
    end

    // R9: no start event, idle target change and ineffective edges
    tick();
    pre = drv;
    tgt = 16'h3C3C; tick(); tick();
    chk("R9 idle target", 32'({busy, drv}), 32'({1'b0, pre}));
    le = 1'b0; tick();
    sck = 1'b1; tick(); tick();
    chk("R9 sck with le low", 32'({busy, drv}), 32'({1'b0, pre}));
    sck = 1'b0;
    oe_n = 1'b1; tick();
    le = 1'b1; tick(); tick();
    chk("R9 le with oe high", 32'({busy, drv}), 32'(0));

    // R8: restart mid-cascade
    blank_prep();
    tgt = 16'hFFFF; oe_n = 1'b0;
    run_seq("R8a", '0, 16'hFFFF, 4);
    base = exp_at('0, 16'hFFFF, 4);
    tgt = 16'h00F0; le = 1'b1;
    run_seq("R8", base, 16'h00F0, LAST + 1);

    // R7: blanking mid-cascade
    blank_prep();
    tgt = 16'hFFFF; oe_n = 1'b0;
    run_seq("R7a", '0, 16'hFFFF, 3);
    oe_n = 1'b1; tick();
    chk("R7 mid blank", 32'({busy, drv}), 32'(0));

    // R1: reset mid-cascade
    oe_n = 1'b0; tgt = 16'hFFFF;
    run_seq("R1a", '0, 16'hFFFF, 4);
    rst_n = 1'b0; tick();
    chk("R1 mid reset", 32'({busy, drv}), 32'(0));
    rst_n = 1'b1; tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule